// File: doc/BRIEF.md
# Real-Mode Segment Cache Loader

This block keeps the hidden cache of six segment registers up to date when software writes a segment register while the core runs without protection (real mode) or in virtual-8086 mode. A write carries a register index, a selector word and the current mode flags. On the fast path the block fills the addressed entry at once. The base is the selector times sixteen, the limit is fixed at 64 KiB minus one, and the attribute word marks a present, writable, accessed code/data segment. Its privilege level depends on the mode.

When protection is enabled and the virtual-8086 flag is clear, the cache is not touched. The block raises a one-cycle request toward a separate descriptor loader and hands over the index and the truncated selector. Any entry can be read back through a registered read port.

Top module: `rmseg_loader`

## Requirements
- R1: After reset every entry reads back as all zeros (selector, base, limit and attribute), and `pm_req` is 0.
- R2: A strobe with `prot_en`=0 or `v86`=1 and an index below 6 takes the fast path: the entry is rewritten and `pm_req` stays 0.
- R3: Only the low 16 bits of `wr_sel` are used; the upper bits have no effect on any output.
- R4: A written entry reads back with base = selector shifted left by 4, zero-extended to 32 bits.
- R5: A written entry reads back with limit 0x0000FFFF.
- R6: The attribute word has P at bit 15, S at bit 12, W at bit 9 and A at bit 8 set; a load with `v86`=0 gives DPL (bits 14:13) = 0, i.e. 0x00009300.
- R7: A load with `v86`=1 gives DPL = 3, i.e. 0x0000F300, whatever `prot_en` is.
- R8: A strobe with `prot_en`=1, `v86`=0 and an index below 6 leaves the cache unchanged and raises `pm_req` for one cycle after the strobe edge, with `pm_idx` and the 16-bit `pm_sel`.
- R9: A write shows on the read port from the clock after the strobe edge; all other entries keep their contents.
- R10: A strobe with index 6 or 7 is ignored: no entry changes and `pm_req` stays 0.
- R11: A read and a write of the same entry in the same cycle return the contents from before that write.
- R12: A read with index 6 or 7 returns all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Segment write strobe |
| wr_idx | input | 3 | Segment index (0 ES, 1 CS, 2 SS, 3 DS, 4 FS, 5 GS) |
| wr_sel | input | 32 | Selector operand; low 16 bits used |
| prot_en | input | 1 | Protection enabled |
| v86 | input | 1 | Virtual-8086 flag |
| rd_idx | input | 3 | Read-back index |
| rd_sel | output | 16 | Selector of the read entry |
| rd_base | output | 32 | Base of the read entry |
| rd_limit | output | 32 | Limit of the read entry |
| rd_attr | output | 32 | Attribute word of the read entry |
| pm_req | output | 1 | Request to the protected-mode descriptor loader |
| pm_idx | output | 3 | Index passed with the request |
| pm_sel | output | 16 | Selector passed with the request |

## Verification
The read port and the write port can address the same entry in the same clock. The bench provokes this by raising the write strobe and setting the read index to that entry in one cycle. The first registered result must still show the earlier contents, and the following cycle must show the new ones. A forwarded load can also coincide with a read of the entry it targets, and the bench confirms that this read stays unchanged.

// File: rtl/rmseg_pkg.sv
package rmseg_pkg;

  localparam int SEL_W   = 16;
  localparam int SHIFT   = 4;
  localparam int ATTR_A  = 8;
  localparam int ATTR_W_ = 9;
  localparam int ATTR_S  = 12;
  localparam int ATTR_DL = 13;
  localparam int ATTR_P  = 15;

  typedef struct packed {
    logic             valid;
    logic             vm;
    logic [SEL_W-1:0] sel;
  } seg_entry_t;

  function automatic logic [31:0] make_attr(input logic vm);
    logic [31:0] a;
    a = '0;
    a[ATTR_P]  = 1'b1;
    a[ATTR_S]  = 1'b1;
    a[ATTR_W_] = 1'b1;
    a[ATTR_A]  = 1'b1;
    a[ATTR_DL+1:ATTR_DL] = vm ? 2'b11 : 2'b00;
    return a;
  endfunction

endpackage

// File: rtl/rmseg_decode.sv
module rmseg_decode #(
  parameter int NUM_SEG  = 6,
  parameter int IDX_W    = 3,
  parameter int SEL_IN_W = 32
) (
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [SEL_IN_W-1:0]        wr_sel,
  input  logic                       prot_en,
  input  logic                       v86,
  output logic                       fast_we,
  output logic                       fwd_we,
  output logic [rmseg_pkg::SEL_W-1:0] sel_trunc
);
  logic idx_ok;
  logic fast_mode;

  always_comb begin
    idx_ok    = (int'(wr_idx) < NUM_SEG);
    fast_mode = !prot_en || v86;
    fast_we   = wr_en && idx_ok && fast_mode;
    fwd_we    = wr_en && idx_ok && !fast_mode;
    sel_trunc = wr_sel[rmseg_pkg::SEL_W-1:0];
  end

endmodule

// File: rtl/rmseg_store.sv
module rmseg_store #(
  parameter int NUM_SEG = 6,
  parameter int IDX_W   = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        fast_we,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [rmseg_pkg::SEL_W-1:0] wr_sel,
  input  logic                        wr_vm,
  output rmseg_pkg::seg_entry_t       entries [NUM_SEG]
);
  import rmseg_pkg::*;

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_ent
    logic hit;
    assign hit = fast_we && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        entries[i] <= '0;
      end else if (hit) begin
        entries[i].valid <= 1'b1;
        entries[i].vm    <= wr_vm;
        entries[i].sel   <= wr_sel;
      end
    end

    assert_keep_R9: assert property (@(posedge clk) disable iff (rst)
      !(fast_we && wr_idx == IDX_W'(i)) |=> $stable(entries[i]));

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
      (fast_we && wr_idx == IDX_W'(i)) |=> (entries[i].valid && entries[i].sel == $past(wr_sel)));
  end

endmodule

// File: rtl/rmseg_view.sv
module rmseg_view #(
  parameter int NUM_SEG = 6,
  parameter int IDX_W   = 3,
  parameter int BASE_W  = 32,
  parameter int LIM_W   = 32,
  parameter int ATTR_W  = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [IDX_W-1:0]            rd_idx,
  input  rmseg_pkg::seg_entry_t       entries [NUM_SEG],
  output logic [rmseg_pkg::SEL_W-1:0] rd_sel,
  output logic [BASE_W-1:0]           rd_base,
  output logic [LIM_W-1:0]            rd_limit,
  output logic [ATTR_W-1:0]           rd_attr
);
  import rmseg_pkg::*;

  localparam logic [LIM_W-1:0] RM_LIMIT = LIM_W'((64'd1 << SEL_W) - 64'd1);

  seg_entry_t pick;
  logic [31:0] attr_full;

  always_comb begin
    pick = '0;
    for (int i = 0; i < NUM_SEG; i++) begin
      if (rd_idx == IDX_W'(i)) pick = entries[i];
    end
    attr_full = make_attr(pick.vm);
  end

  always_ff @(posedge clk) begin
    if (rst || !pick.valid) begin
      rd_sel   <= '0;
      rd_base  <= '0;
      rd_limit <= '0;
      rd_attr  <= '0;
    end else begin
      rd_sel   <= pick.sel;
      rd_base  <= BASE_W'(pick.sel) << SHIFT;
      rd_limit <= RM_LIMIT;
      rd_attr  <= ATTR_W'(attr_full);
    end
  end

  assert_limit_R5: assert property (@(posedge clk) disable iff (rst)
    rd_attr[ATTR_P] |-> (rd_limit == RM_LIMIT));

  assert_base_R4: assert property (@(posedge clk) disable iff (rst)
    rd_attr[ATTR_P] |-> (rd_base == (BASE_W'(rd_sel) << SHIFT)));

  assert_empty_R12: assert property (@(posedge clk) disable iff (rst)
    !rd_attr[ATTR_P] |-> (rd_sel == '0 && rd_base == '0 && rd_limit == '0));

endmodule

// File: rtl/rmseg_loader.sv
module rmseg_loader #(
  parameter int NUM_SEG  = 6,
  parameter int IDX_W    = $clog2(NUM_SEG),
  parameter int SEL_IN_W = 32,
  parameter int BASE_W   = 32,
  parameter int LIM_W    = 32,
  parameter int ATTR_W   = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [SEL_IN_W-1:0]         wr_sel,
  input  logic                        prot_en,
  input  logic                        v86,
  input  logic [IDX_W-1:0]            rd_idx,
  output logic [rmseg_pkg::SEL_W-1:0] rd_sel,
  output logic [BASE_W-1:0]           rd_base,
  output logic [LIM_W-1:0]            rd_limit,
  output logic [ATTR_W-1:0]           rd_attr,
  output logic                        pm_req,
  output logic [IDX_W-1:0]            pm_idx,
  output logic [rmseg_pkg::SEL_W-1:0] pm_sel
);
  import rmseg_pkg::*;

  logic             fast_we;
  logic             fwd_we;
  logic [SEL_W-1:0] sel_trunc;
  seg_entry_t       entries [NUM_SEG];

  rmseg_decode #(.NUM_SEG(NUM_SEG), .IDX_W(IDX_W), .SEL_IN_W(SEL_IN_W)) u_decode (
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_sel(wr_sel), .prot_en(prot_en), .v86(v86),
    .fast_we(fast_we), .fwd_we(fwd_we), .sel_trunc(sel_trunc)
  );

  rmseg_store #(.NUM_SEG(NUM_SEG), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst), .fast_we(fast_we), .wr_idx(wr_idx),
    .wr_sel(sel_trunc), .wr_vm(v86), .entries(entries)
  );

  rmseg_view #(.NUM_SEG(NUM_SEG), .IDX_W(IDX_W), .BASE_W(BASE_W),
               .LIM_W(LIM_W), .ATTR_W(ATTR_W)) u_view (
    .clk(clk), .rst(rst), .rd_idx(rd_idx), .entries(entries),
    .rd_sel(rd_sel), .rd_base(rd_base), .rd_limit(rd_limit), .rd_attr(rd_attr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pm_req <= 1'b0;
      pm_idx <= '0;
      pm_sel <= '0;
    end else begin
      pm_req <= fwd_we;
      if (fwd_we) begin
        pm_idx <= wr_idx;
        pm_sel <= sel_trunc;
      end
    end
  end

  assert_fwd_only_R8: assert property (@(posedge clk) disable iff (rst)
    pm_req |-> $past(wr_en && prot_en && !v86 && (int'(wr_idx) < NUM_SEG)));

  assert_fast_noreq_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (!prot_en || v86)) |=> !pm_req);

  assert_badidx_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (int'(wr_idx) >= NUM_SEG)) |=> !pm_req);

endmodule

// File: tb/rmseg_loader_tb.sv
module rmseg_loader_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NSEG = 6;

  typedef struct packed {
    logic [2:0]  idx;
    logic [31:0] sel;
    logic        pe;
    logic        vm;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VEC [NVEC] = '{
    '{3'd1, 32'h0000_1234, 1'b0, 1'b0},
    '{3'd3, 32'hABCD_F00F, 1'b0, 1'b0},
    '{3'd2, 32'h0000_FFFF, 1'b1, 1'b1},
    '{3'd5, 32'h1234_0001, 1'b0, 1'b1},
    '{3'd0, 32'h0000_0000, 1'b0, 1'b0},
    '{3'd4, 32'h0000_8001, 1'b1, 1'b0},
    '{3'd6, 32'h0000_5555, 1'b0, 1'b0},
    '{3'd7, 32'h0000_0001, 1'b1, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [31:0] wr_sel = '0;
  logic        prot_en = 1'b0;
  logic        v86 = 1'b0;
  logic [2:0]  rd_idx = '0;
  logic [15:0] rd_sel;
  logic [31:0] rd_base, rd_limit, rd_attr;
  logic        pm_req;
  logic [2:0]  pm_idx;
  logic [15:0] pm_sel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic        m_valid [NSEG];
  logic        m_vm    [NSEG];
  logic [15:0] m_sel   [NSEG];

  always #(CLK_PERIOD/2) clk = ~clk;

  rmseg_loader u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_sel(wr_sel),
    .prot_en(prot_en), .v86(v86), .rd_idx(rd_idx),
    .rd_sel(rd_sel), .rd_base(rd_base), .rd_limit(rd_limit), .rd_attr(rd_attr),
    .pm_req(pm_req), .pm_idx(pm_idx), .pm_sel(pm_sel)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_attr(input logic vm);
    return vm ? 32'h0000_F300 : 32'h0000_9300;
  endfunction

  task automatic check_entry(input string req, input int i);
    @(negedge clk) rd_idx = 3'(i);
    @(negedge clk);
    if (i < NSEG && m_valid[i]) begin
      chk(req, "sel", {16'h0, rd_sel}, {16'h0, m_sel[i]});
      chk("R4", "base", rd_base, {12'h0, m_sel[i], 4'h0});
      chk("R5", "limit", rd_limit, 32'h0000_FFFF);
      chk(m_vm[i] ? "R7" : "R6", "attr", rd_attr, exp_attr(m_vm[i]));
    end else begin
      chk(req, "empty sel", {16'h0, rd_sel}, 32'h0);
      chk(req, "empty base", rd_base, 32'h0);
      chk(req, "empty limit", rd_limit, 32'h0);
      chk(req, "empty attr", rd_attr, 32'h0);
    end
  endtask

  task automatic do_write(input vec_t v);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = v.idx; wr_sel = v.sel; prot_en = v.pe; v86 = v.vm;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NSEG; i++) begin
      m_valid[i] = 1'b0; m_vm[i] = 1'b0; m_sel[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1", "pm_req", {31'h0, pm_req}, 32'h0);
    for (int i = 0; i < NSEG; i++) check_entry("R1", i);

    // Table walk: R2/R3/R8/R9/R10
    for (int k = 0; k < NVEC; k++) begin
      vec_t v;
      bit fast, fwd, ok;
      v = VEC[k];
      ok = (int'(v.idx) < NSEG);
      fast = ok && (!v.pe || v.vm);
      fwd = ok && v.pe && !v.vm;
      do_write(v);
      chk(fwd ? "R8" : (ok ? "R2" : "R10"), "pm_req", {31'h0, pm_req}, {31'h0, fwd});
      if (fwd) begin
        chk("R8", "pm_idx", {29'h0, pm_idx}, {29'h0, v.idx});
        chk("R3", "pm_sel", {16'h0, pm_sel}, {16'h0, v.sel[15:0]});
        @(negedge clk);
        chk("R8", "pm_req one cycle", {31'h0, pm_req}, 32'h0);
      end
      if (fast) begin
        m_valid[v.idx] = 1'b1; m_vm[v.idx] = v.vm; m_sel[v.idx] = v.sel[15:0];
      end
      for (int i = 0; i < NSEG; i++) check_entry(fwd ? "R8" : (ok ? "R9" : "R10"), i);
    end

    // R3: upper bits ignored (0xABCD_F00F stored as F00F)
    check_entry("R3", 3);

    // R12: out-of-range read indices
    check_entry("R12", 6);
    check_entry("R12", 7);

    // R11: same-cycle read and write of entry 1
    @(negedge clk);
    rd_idx = 3'd1;
    wr_en = 1'b1; wr_idx = 3'd1; wr_sel = 32'h0000_7777; prot_en = 1'b0; v86 = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R11", "old sel", {16'h0, rd_sel}, 32'h0000_1234);
    m_sel[1] = 16'h7777;
    @(negedge clk);
    chk("R9", "new sel next cycle", {16'h0, rd_sel}, 32'h0000_7777);
    chk("R4", "new base", rd_base, 32'h0007_7770);

    // R8: forwarded load during a read of its target leaves it unchanged
    @(negedge clk);
    rd_idx = 3'd1;
    wr_en = 1'b1; wr_idx = 3'd1; wr_sel = 32'h0000_2222; prot_en = 1'b1; v86 = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R8", "pm_req", {31'h0, pm_req}, 32'h1);
    @(negedge clk);
    chk("R8", "cache kept", {16'h0, rd_sel}, 32'h0000_7777);

    // R7: v86 with protection off still gives DPL 3 (entry 5 from table)
    check_entry("R7", 5);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule